// File: doc/BRIEF.md
# Byte-Addressed Register Port with Interrupt Aggregation

This block is the register side of a byte-serial slave device. A host-side protocol engine, which is not part of the block, turns bus traffic into four strobes: one for the start of a write transfer, one for each written byte, one for each byte the host wants to read, and the data byte itself. The first byte after a write start selects a register through an 8-bit pointer. Every byte written after that goes to the register at the pointer, and every read returns the register at the pointer. The pointer steps forward after each access, so a burst covers consecutive addresses.

The block gathers event pulses from neighbouring logic into a 16-bit interrupt status word. These sources are a periodic tick, an alarm, a clock-update error and rising edges of a push-button line. A 16-bit mask gates the status word onto one level interrupt line. Software reads the status through two byte registers. It clears status bits by writing ones to two acknowledge registers. The block also holds a fixed revision code, a small oscillator control field, a saturating voltage-select field and a self-reset command register.

Top module: `regport_top`

## Requirements
- R1: After `wr_start`, the next `wr_byte` loads its data into the pointer and writes no register. The start strobe takes priority over a byte strobe in the same cycle.
- R2: Each later `wr_byte` writes its data to the register at the pointer, then the pointer adds one. The pointer wraps from 0xFF to 0x00.
- R3: A `rd_byte` places the register at the pointer on `rdata` on the clock edge that samples it, then the pointer adds one (wrapping at 0xFF).
- R4: Synchronous reset sets the pointer to 0x00, the mask to 0x0FFF, the status to 0, `irq` to 0 and `rdata` to 0.
- R5: The mask's low byte is at address 0x17 and its high byte at 0x18. A write to one of them changes only that byte.
- R6: The status low byte reads at 0x19 and the high byte at 0x1A. Writes to these two addresses have no effect.
- R7: A write to 0x1B clears the status bits 7:0 that are one in the data. A write to 0x1C does the same for bits 15:8. Both addresses read as 0x00.
- R8: A one-cycle pulse on `ev_tick`, `ev_alarm` or `ev_clkerr` sets status bit 8, 9 or 10. A low-to-high change of `btn` sets bit 11, and holding `btn` high sets nothing further.
- R9: An event in the same cycle as an acknowledge of its own bit leaves the bit set.
- R10: `irq` is high exactly when some status bit is set and its mask bit is clear. It follows one clock edge after the status or mask register changes.
- R11: Address 0x01 reads 0x22 and ignores writes. Address 0x15 keeps the low 3 bits written (reset value 1) and reads them with bit 7 set.
- R12: Address 0x03 stores the low 5 bits of the written value, limited to at most 0x12. Its reset value is 0x05.
- R13: A write to 0x14 with bit 0 set returns the mask, status, oscillator and voltage-select registers to their reset values. A write with bit 0 clear has no effect. Address 0x14 reads 0x00.
- R14: Addresses with no register read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_start | input | 1 | Start of a write transfer; arms pointer loading |
| wr_byte | input | 1 | Written byte strobe |
| rd_byte | input | 1 | Read byte strobe |
| wdata | input | 8 | Written byte |
| ev_tick | input | 1 | Periodic timer event pulse |
| ev_alarm | input | 1 | Alarm event pulse |
| ev_clkerr | input | 1 | Clock update error pulse |
| btn | input | 1 | Push-button level |
| rdata | output | 8 | Read byte, valid after the sampling edge |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its package defaults: an 8-bit pointer and byte lane, and a 16-bit status and mask. With these values the full pointer wrap from 0xFF to 0x00 takes only a few strobes. Both mask bytes, the per-byte acknowledge paths and the four event bits can also be driven directly. The corner cases covered are:
- a same-cycle event and acknowledge;
- a button held high across an acknowledge;
- an address byte that must not be written as data;
- a soft-reset command with bit 0 clear and with bit 0 set.

// File: rtl/regport_pkg.sv
package regport_pkg;

    localparam int DW = 8;
    localparam int AW = 8;
    localparam int SW = 2 * DW;
    localparam int VW = 5;
    localparam int OW = 3;

    typedef enum logic [AW-1:0] {
        A_REV    = 8'h01,
        A_VSEL   = 8'h03,
        A_OFF    = 8'h14,
        A_OSC    = 8'h15,
        A_MSK_LO = 8'h17,
        A_MSK_HI = 8'h18,
        A_STS_LO = 8'h19,
        A_STS_HI = 8'h1A,
        A_ACK_LO = 8'h1B,
        A_ACK_HI = 8'h1C
    } reg_addr_e;

    localparam logic [DW-1:0] REV_CODE = 8'h22;
    localparam logic [VW-1:0] VSEL_RST = 5'h05;
    localparam logic [VW-1:0] VSEL_MAX = 5'h12;
    localparam logic [OW-1:0] OSC_RST  = 3'b001;
    localparam logic [SW-1:0] MSK_RST  = 16'h0FFF;

    localparam int B_TICK   = 8;
    localparam int B_ALARM  = 9;
    localparam int B_CLKERR = 10;
    localparam int B_BUTTON = 11;

    typedef struct packed {
        logic button;
        logic clkerr;
        logic alarm;
        logic tick;
    } evt_t;

    function automatic logic [VW-1:0] vsel_limit(input logic [VW-1:0] v);
        return (v > VSEL_MAX) ? VSEL_MAX : v;
    endfunction

endpackage

// File: rtl/regport_ptr.sv
module regport_ptr
    import regport_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_start,
    input  logic          wr_byte,
    input  logic          rd_byte,
    input  logic [DW-1:0] wdata,
    output logic          wr_en,
    output logic          rd_en,
    output logic [AW-1:0] addr
);
    logic          first_q;
    logic [AW-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            first_q <= 1'b0;
            ptr_q   <= '0;
        end else if (wr_start) begin
            first_q <= 1'b1;
        end else if (wr_byte) begin
            if (first_q) begin
                ptr_q   <= wdata[AW-1:0];
                first_q <= 1'b0;
            end else begin
                ptr_q <= ptr_q + 1'b1;
            end
        end else if (rd_byte) begin
            ptr_q <= ptr_q + 1'b1;
        end
    end

    assign wr_en = wr_byte & ~first_q & ~wr_start;
    assign rd_en = rd_byte & ~wr_byte & ~wr_start;
    assign addr  = ptr_q;

    // R1: the address byte lands in the pointer and disarms the flag
    a_r1_addr_load: assert property (@(posedge clk) disable iff (rst)
        (wr_byte && first_q && !wr_start) |=> (ptr_q == $past(wdata)) && !first_q);

    // R2: data bytes advance the pointer by one, with wrap
    a_r2_wr_advance: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ptr_q == AW'($past(ptr_q) + 1));

    // R3: reads advance the pointer by one, with wrap
    a_r3_rd_advance: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> ptr_q == AW'($past(ptr_q) + 1));

endmodule

// File: rtl/regport_cfg.sv
module regport_cfg
    import regport_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [VW-1:0] vsel,
    output logic [OW-1:0] osc,
    output logic          soft_rst
);
    logic [VW-1:0] vsel_q;
    logic [OW-1:0] osc_q;

    assign soft_rst = wr_en && (addr == A_OFF) && wdata[0];

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            vsel_q <= VSEL_RST;
            osc_q  <= OSC_RST;
        end else if (wr_en) begin
            if (addr == A_VSEL) vsel_q <= vsel_limit(wdata[VW-1:0]);
            if (addr == A_OSC)  osc_q  <= wdata[OW-1:0];
        end
    end

    assign vsel = vsel_q;
    assign osc  = osc_q;

    // R12: the stored voltage select never exceeds its ceiling
    a_r12_vsel_ceiling: assert property (@(posedge clk) disable iff (rst)
        vsel_q <= VSEL_MAX);

    // R13: the self-reset command restores defaults
    a_r13_soft_defaults: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (vsel_q == VSEL_RST) && (osc_q == OSC_RST));

endmodule

// File: rtl/regport_irq.sv
module regport_irq
    import regport_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          soft_rst,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          ev_tick,
    input  logic          ev_alarm,
    input  logic          ev_clkerr,
    input  logic          btn,
    output logic [SW-1:0] mask,
    output logic [SW-1:0] status,
    output logic          irq
);
    logic [SW-1:0] mask_q, status_q, set_v, ack_v;
    logic          btn_q;
    evt_t          ev;

    always_ff @(posedge clk) begin
        if (rst) btn_q <= 1'b0;
        else     btn_q <= btn;
    end

    always_comb begin
        ev.tick   = ev_tick;
        ev.alarm  = ev_alarm;
        ev.clkerr = ev_clkerr;
        ev.button = btn & ~btn_q;
        set_v = '0;
        set_v[B_TICK]   = ev.tick;
        set_v[B_ALARM]  = ev.alarm;
        set_v[B_CLKERR] = ev.clkerr;
        set_v[B_BUTTON] = ev.button;
        ack_v = '0;
        if (wr_en && addr == A_ACK_LO) ack_v[DW-1:0]  = wdata;
        if (wr_en && addr == A_ACK_HI) ack_v[SW-1:DW] = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            mask_q   <= MSK_RST;
            status_q <= '0;
        end else begin
            status_q <= (status_q & ~ack_v) | set_v;
            if (wr_en && addr == A_MSK_LO) mask_q[DW-1:0]  <= wdata;
            if (wr_en && addr == A_MSK_HI) mask_q[SW-1:DW] <= wdata;
        end
    end

    assign mask   = mask_q;
    assign status = status_q;
    assign irq    = |(status_q & ~mask_q);

    // R8: a tick pulse is recorded
    a_r8_tick_sets: assert property (@(posedge clk) disable iff (rst)
        (ev_tick && !soft_rst) |=> status_q[B_TICK]);

    // R9: a same-cycle acknowledge does not defeat a new alarm
    a_r9_event_wins: assert property (@(posedge clk) disable iff (rst)
        (ev_alarm && wr_en && addr == A_ACK_HI && wdata[1] && !soft_rst)
            |=> status_q[B_ALARM]);

    // R7: acknowledge clears the alarm bit when no new alarm arrives
    a_r7_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_ACK_HI && wdata[1] && !ev_alarm) |=> !status_q[B_ALARM]);

    // R5: a low-byte mask write leaves the high byte alone
    a_r5_mask_lo_only: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_MSK_LO && !soft_rst)
            |=> (mask_q[DW-1:0] == $past(wdata)) && (mask_q[SW-1:DW] == $past(mask_q[SW-1:DW])));

    // R10: a fully masked word cannot interrupt
    a_r10_all_masked: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '1) |-> !irq);

endmodule

// File: rtl/regport_top.sv
module regport_top
    import regport_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_start,
    input  logic       wr_byte,
    input  logic       rd_byte,
    input  logic [7:0] wdata,
    input  logic       ev_tick,
    input  logic       ev_alarm,
    input  logic       ev_clkerr,
    input  logic       btn,
    output logic [7:0] rdata,
    output logic       irq
);
    logic          wr_en, rd_en, soft_rst;
    logic [AW-1:0] addr;
    logic [VW-1:0] vsel;
    logic [OW-1:0] osc;
    logic [SW-1:0] mask, status;
    logic [DW-1:0] rd_val;
    logic [DW-1:0] rdata_q;

    regport_ptr u_ptr (
        .clk(clk), .rst(rst), .wr_start(wr_start), .wr_byte(wr_byte),
        .rd_byte(rd_byte), .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en), .addr(addr)
    );

    regport_cfg u_cfg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .vsel(vsel), .osc(osc), .soft_rst(soft_rst)
    );

    regport_irq u_irq (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .ev_tick(ev_tick), .ev_alarm(ev_alarm), .ev_clkerr(ev_clkerr),
        .btn(btn), .mask(mask), .status(status), .irq(irq)
    );

    always_comb begin
        case (addr)
            A_REV:    rd_val = REV_CODE;
            A_VSEL:   rd_val = DW'(vsel);
            A_OSC:    rd_val = {1'b1, {(DW-OW-1){1'b0}}, osc};
            A_MSK_LO: rd_val = mask[DW-1:0];
            A_MSK_HI: rd_val = mask[SW-1:DW];
            A_STS_LO: rd_val = status[DW-1:0];
            A_STS_HI: rd_val = status[SW-1:DW];
            default:  rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_val;
    end

    assign rdata = rdata_q;

    // R4: reset leaves the interrupt and read byte low
    a_r4_reset_quiet: assert property (@(posedge clk)
        rst |=> !irq && (rdata == 8'h00));

    // R11: the revision code is fixed
    a_r11_revision: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == A_REV) |=> rdata == 8'h22);

    // R7: acknowledge registers read as zero
    a_r7_ack_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (addr == A_ACK_LO || addr == A_ACK_HI)) |=> rdata == 8'h00);

endmodule

// File: tb/regport_top_tb.sv
`timescale 1ns/1ps
module regport_top_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_start = 1'b0, wr_byte = 1'b0, rd_byte = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       ev_tick = 1'b0, ev_alarm = 1'b0, ev_clkerr = 1'b0, btn = 1'b0;
    logic [7:0] rdata;
    logic       irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    regport_top u_dut (
        .clk(clk), .rst(rst), .wr_start(wr_start), .wr_byte(wr_byte), .rd_byte(rd_byte),
        .wdata(wdata), .ev_tick(ev_tick), .ev_alarm(ev_alarm), .ev_clkerr(ev_clkerr),
        .btn(btn), .rdata(rdata), .irq(irq)
    );

    // monitor: each sampled read strobe produces one byte to compare
    initial begin
        forever begin
            @(posedge clk);
            if (rd_byte && !rst) begin
                @(negedge clk);
                n_chk++;
                if (exp_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL scoreboard: read with no expectation, actual %02h expected none", rdata);
                end else begin
                    logic [7:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (rdata !== e) begin
                        n_fail++;
                        $display("FAIL %s: rdata actual %02h expected %02h", t, rdata, e);
                    end
                end
            end
        end
    end

    task automatic chk_irq(input logic e, input string t);
        n_chk++;
        if (irq !== e) begin
            n_fail++;
            $display("FAIL %s: irq actual %0b expected %0b", t, irq, e);
        end
    endtask

    task automatic set_ptr(input logic [7:0] a);
        @(negedge clk); wr_start = 1'b1;
        @(negedge clk); wr_start = 1'b0; wr_byte = 1'b1; wdata = a;
        @(negedge clk); wr_byte = 1'b0;
    endtask

    task automatic wr_data(input logic [7:0] d);
        @(negedge clk); wr_byte = 1'b1; wdata = d;
        @(negedge clk); wr_byte = 1'b0;
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        set_ptr(a);
        wr_data(d);
    endtask

    task automatic rd_next(input logic [7:0] e, input string t);
        @(negedge clk);
        exp_q.push_back(e);
        tag_q.push_back(t);
        rd_byte = 1'b1;
        @(negedge clk); rd_byte = 1'b0;
    endtask

    task automatic rd_at(input logic [7:0] a, input logic [7:0] e, input string t);
        set_ptr(a);
        rd_next(e, t);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run hung, actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_irq(1'b0, "R4 irq after reset");
        // R4/R3: pointer starts at 0x00 and advances on reads
        rd_next(8'h00, "R4 R14 pointer zero, empty address");
        rd_next(8'h22, "R3 R11 auto-increment to revision");
        rd_at(8'h17, 8'hFF, "R4 mask low reset");
        rd_next(8'h0F, "R4 mask high reset");
        rd_next(8'h00, "R4 status low reset");
        rd_next(8'h00, "R4 status high reset");
        rd_at(8'h03, 8'h05, "R12 vsel reset");
        rd_at(8'h15, 8'h81, "R11 osc reset with bit7");

        // R12: saturation and field width
        wr_reg(8'h03, 8'h1F); rd_at(8'h03, 8'h12, "R12 saturate 0x1F");
        wr_reg(8'h03, 8'h0B); rd_at(8'h03, 8'h0B, "R12 in range");
        wr_reg(8'h03, 8'hE7); rd_at(8'h03, 8'h07, "R12 low five bits");
        // R11
        wr_reg(8'h15, 8'hFE); rd_at(8'h15, 8'h86, "R11 osc three bits");
        wr_reg(8'h01, 8'h00); rd_at(8'h01, 8'h22, "R11 revision ignores write");
        // R14
        wr_reg(8'h40, 8'h55); rd_at(8'h40, 8'h00, "R14 unknown address");

        // R8 / R10: tick masked by reset mask
        @(negedge clk); ev_tick = 1'b1;
        @(negedge clk); ev_tick = 1'b0;
        chk_irq(1'b0, "R10 tick masked");
        rd_at(8'h1A, 8'h01, "R8 tick sets bit 8");
        // R2/R5: burst write of both mask bytes
        set_ptr(8'h17); wr_data(8'hFF); wr_data(8'h0E);
        chk_irq(1'b1, "R10 unmask raises irq");
        rd_at(8'h17, 8'hFF, "R5 low byte kept");
        rd_next(8'h0E, "R2 R5 high byte via auto-increment");
        // R6
        wr_reg(8'h1A, 8'h00); rd_at(8'h1A, 8'h01, "R6 status write ignored");
        // R7
        wr_reg(8'h1C, 8'h01);
        chk_irq(1'b0, "R7 R10 ack drops irq");
        rd_at(8'h1A, 8'h00, "R7 ack clears bit 8");
        rd_at(8'h1B, 8'h00, "R7 ack low reads zero");
        rd_next(8'h00, "R7 ack high reads zero");
        // R8: alarm and error, then per-bit ack
        @(negedge clk); ev_alarm = 1'b1; ev_clkerr = 1'b1;
        @(negedge clk); ev_alarm = 1'b0; ev_clkerr = 1'b0;
        rd_at(8'h1A, 8'h06, "R8 alarm and clock error");
        wr_reg(8'h1C, 8'h02); rd_at(8'h1A, 8'h04, "R7 ack only bit 9");
        // R9: event and acknowledge in the same cycle
        set_ptr(8'h1C);
        @(negedge clk); wr_byte = 1'b1; wdata = 8'h01; ev_tick = 1'b1;
        @(negedge clk); wr_byte = 1'b0; ev_tick = 1'b0;
        rd_at(8'h1A, 8'h05, "R9 event beats ack");
        // R8: button edge only
        @(negedge clk); btn = 1'b1;
        repeat (4) @(negedge clk);
        rd_at(8'h1A, 8'h0D, "R8 button press");
        wr_reg(8'h1C, 8'h08);
        repeat (4) @(negedge clk);
        rd_at(8'h1A, 8'h05, "R8 held button no re-set");
        @(negedge clk); btn = 1'b0;
        @(negedge clk); btn = 1'b1;
        @(negedge clk);
        rd_at(8'h1A, 8'h0D, "R8 second press");
        // R13
        wr_reg(8'h14, 8'h00); rd_at(8'h15, 8'h86, "R13 bit0 clear no effect");
        wr_reg(8'h14, 8'h01);
        chk_irq(1'b0, "R13 irq after soft reset");
        rd_at(8'h15, 8'h81, "R13 osc default");
        rd_at(8'h03, 8'h05, "R13 vsel default");
        rd_at(8'h17, 8'hFF, "R13 mask low default");
        rd_next(8'h0F, "R13 mask high default");
        rd_next(8'h00, "R13 status low cleared");
        rd_next(8'h00, "R13 status high cleared");
        rd_at(8'h14, 8'h00, "R13 command reads zero");
        // R3 wrap on reads
        rd_at(8'hFF, 8'h00, "R3 read at 0xFF");
        rd_next(8'h00, "R3 wrap to 0x00");
        rd_next(8'h22, "R3 wrap continues to 0x01");
        // R2 wrap on writes: 0xFF,0x00,0x01,0x02 then 0x03
        set_ptr(8'hFF);
        wr_data(8'hAA); wr_data(8'hAA); wr_data(8'hAA); wr_data(8'hAA); wr_data(8'h10);
        rd_at(8'h03, 8'h10, "R2 write wrap reaches 0x03");
        // R1: address byte is not written as data
        set_ptr(8'h15);
        set_ptr(8'h03);
        rd_next(8'h10, "R1 pointer loaded from address byte");
        rd_at(8'h15, 8'h81, "R1 address byte did not write osc");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_chk++; n_fail++;
            $display("FAIL scoreboard: %0d reads outstanding, expected 0", exp_q.size());
        end
        finish_run();
    end
endmodule